// File: doc/BRIEF.md
# Gated Dual Timer/Counter

The block holds two identical up-counting channels that share one 8-bit configuration register. Each channel advances either once per machine cycle (twelve core clocks) or once per falling edge on its own count pin. Each channel has a gate option. With the gate clear, the software run bit alone starts and stops the channel. With the gate set, the channel only advances while the run bit and the channel's interrupt pin are both high. This makes it possible to measure the width of a pulse on that pin.

Each channel offers three counting layouts: a 13-bit counter built from a 5-bit prescaler under an 8-bit high byte, a plain 16-bit counter, and an 8-bit counter that reloads from the high byte. An overflow latches a flag that software clears by writing it back to 0. All state is reached through a small register port. Writes take effect on the clock edge. Reads are combinational on the current address.

Top module: `gated_timer_unit`

## Requirements
- R1: The register port decodes addr_i 0 = config, 1 = control, 2/3 = channel 0 low/high byte, 4/5 = channel 1 low/high byte. Every one of these reads back the value last written to it unless counting has changed it since. In the config byte, bits 3..0 belong to channel 0 and bits 7..4 to channel 1; each nibble is {gate, external, mode[1:0]}.
- R2: With a channel's gate bit at 0, its interrupt pin has no effect. The channel advances whenever its run bit (control bit 0 for channel 0, bit 1 for channel 1) is 1, and it holds when the run bit is 0.
- R3: With the gate bit at 1, the channel advances only while the run bit is 1 and the interrupt pin, seen through a two-stage synchronizer, is 1. It stops while either is 0 and resumes when both return to 1.
- R4: With the external bit at 0, an enabled channel increments exactly once per 12 clocks, on the last clock of the machine cycle.
- R5: With the external bit at 1, the channel increments once for each 1-to-0 change of its count pin. The pin is synchronized and then sampled once per machine cycle. A fall seen between two consecutive samples causes one increment at the following machine-cycle boundary, so the rate is at most one count per two machine cycles.
- R6: Mode 00 counts the low byte's bits 4..0 as a prescaler that carries into the high byte. Low bits 7..5 are left untouched. The channel overflows when the high byte is 0xFF and the prescaler is 31.
- R7: Mode 01 counts {high, low} as a 16-bit value and overflows from 0xFFFF to 0x0000.
- R8: Mode 10 counts the low byte only. When it overflows from 0xFF, the low byte is loaded with the high byte, and the high byte is never changed by counting.
- R9: An overflow sets the channel's flag (control bit 2 for channel 0, bit 3 for channel 1, also driven on tf_o). The flag stays set until a control write puts 0 in that bit. A control write in the same cycle as an overflow wins.
- R10: A write to either counter byte of a channel cancels that channel's increment, and any overflow, in the same cycle; the written value is stored.
- R11: Mode 11 holds the channel's counter bytes regardless of run, gate and pins.
- R12: After reset every register reads 0 and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| cnt_pin_i | input | 2 | External count pins, bit n for channel n |
| int_pin_i | input | 2 | Interrupt pins used as gate levels, bit n for channel n |
| tf_o | output | 2 | Overflow flags, bit n for channel n |

## Verification
The hold properties assume that only a counter-byte write or an increment can change a channel's counter bytes. Each property names the write strobes as its only exception, so the bench is free to write at any time, including on the increment cycle. The pins are treated as fully asynchronous. The bench changes them one clock after an edge at irregular spacings, some faster than the machine cycle, so the synchronizer and the once-per-cycle sampling both get exercised. The mode and gate bits are assumed to be changed only through the config write. The bench rewrites them only between test phases and lets the behavioural model track every write.

// File: rtl/gtu_pkg.sv
package gtu_pkg;
  localparam int DATA_W = 8;
  localparam int NUM_CH = 2;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CFG  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_LO0  = 3'd2;

  typedef enum logic [1:0] {
    MODE_13  = 2'b00,
    MODE_16  = 2'b01,
    MODE_8R  = 2'b10,
    MODE_OFF = 2'b11
  } cnt_mode_e;

  typedef struct packed {
    logic      gate;
    logic      ext;
    cnt_mode_e mode;
  } chan_cfg_t;
endpackage

// File: rtl/gtu_sync.sv
module gtu_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gtu_edge_det.sv
module gtu_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic pin_i,
  output logic fall_o
);
  logic smp_q, prv_q;

  // one sample per machine cycle; the older sample survives one more cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q <= 1'b0;
      prv_q <= 1'b0;
    end else if (tick_i) begin
      smp_q <= pin_i;
      prv_q <= smp_q;
    end
  end

  assign fall_o = prv_q & ~smp_q;

  // R5
  fall_pace_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && fall_o) |=> !fall_o);
endmodule

// File: rtl/gtu_channel.sv
module gtu_channel
  import gtu_pkg::*;
#(
  parameter int PRESCALE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  chan_cfg_t         cfg_i,
  input  logic              run_i,
  input  logic              int_i,
  input  logic              pin_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] lo_o,
  output logic [DATA_W-1:0] hi_o,
  output logic              ovf_o
);
  logic [DATA_W-1:0] lo_q, hi_q, lo_n, hi_n;
  logic fall, en, inc, wr_any, ovf_raw;

  gtu_edge_det u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .pin_i (pin_i),
    .fall_o(fall)
  );

  assign wr_any = wr_lo_i | wr_hi_i;
  assign en     = run_i & (~cfg_i.gate | int_i);
  assign inc    = tick_i & en & (~cfg_i.ext | fall) & ~wr_any;

  always_comb begin
    lo_n    = lo_q;
    hi_n    = hi_q;
    ovf_raw = 1'b0;
    if (inc) begin
      unique case (cfg_i.mode)
        MODE_13: begin
          if (&lo_q[PRESCALE_W-1:0]) begin
            lo_n[PRESCALE_W-1:0] = '0;
            hi_n                 = hi_q + 1'b1;
            ovf_raw              = &hi_q;
          end else begin
            lo_n[PRESCALE_W-1:0] = lo_q[PRESCALE_W-1:0] + 1'b1;
          end
        end
        MODE_16: begin
          {hi_n, lo_n} = {hi_q, lo_q} + 1'b1;
          ovf_raw      = &{hi_q, lo_q};
        end
        MODE_8R: begin
          if (&lo_q) begin
            lo_n    = hi_q;
            ovf_raw = 1'b1;
          end else begin
            lo_n = lo_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
    if (wr_lo_i) lo_n = wdata_i;
    if (wr_hi_i) hi_n = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_n;
      hi_q <= hi_n;
    end
  end

  assign lo_o  = lo_q;
  assign hi_o  = hi_q;
  assign ovf_o = ovf_raw;

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !wr_any) |=> $stable({hi_q, lo_q}));
  // R3
  gate_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.gate && !int_i && !wr_any) |=> $stable({hi_q, lo_q}));
  // R4
  tick_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_any) |=> $stable({hi_q, lo_q}));
  // R8
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc && cfg_i.mode == MODE_8R && (&lo_q)) |=> (lo_q == $past(hi_q) && $stable(hi_q)));
  // R10
  write_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> (lo_q == $past(wdata_i)));
  // R11
  mode_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.mode == MODE_OFF && !wr_any) |=> $stable({hi_q, lo_q}));
endmodule

// File: rtl/gated_timer_unit.sv
module gated_timer_unit
  import gtu_pkg::*;
#(
  parameter int CLKS_PER_MC = 12,
  parameter int PRESCALE_W  = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NUM_CH-1:0] cnt_pin_i,
  input  logic [NUM_CH-1:0] int_pin_i,
  output logic [NUM_CH-1:0] tf_o
);
  localparam int PH_W = $clog2(CLKS_PER_MC);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLKS_PER_MC - 1);

  logic [PH_W-1:0]   phase_q;
  logic              tick;
  logic [DATA_W-1:0] cfg_q;
  logic [NUM_CH-1:0] run_q, tf_q, ovf, int_s, cnt_s;
  logic [DATA_W-1:0] lo_w [NUM_CH];
  logic [DATA_W-1:0] hi_w [NUM_CH];
  logic              we_cfg, we_ctrl;

  // machine-cycle phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                phase_q <= '0;
    else if (phase_q == PH_LAST) phase_q <= '0;
    else                        phase_q <= phase_q + 1'b1;
  end
  assign tick = (phase_q == PH_LAST);

  gtu_sync #(.WIDTH(2*NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({int_pin_i, cnt_pin_i}),
    .q_o   ({int_s, cnt_s})
  );

  assign we_cfg  = we_i && (addr_i == ADDR_CFG);
  assign we_ctrl = we_i && (addr_i == ADDR_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      run_q <= '0;
      tf_q  <= '0;
    end else begin
      if (we_cfg) cfg_q <= wdata_i;
      if (we_ctrl) begin
        run_q <= wdata_i[NUM_CH-1:0];
        tf_q  <= wdata_i[2*NUM_CH-1:NUM_CH];
      end else begin
        tf_q <= tf_q | ovf;
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_LO = ADDR_LO0 + ADDR_W'(2*c);
    localparam logic [ADDR_W-1:0] A_HI = ADDR_LO0 + ADDR_W'(2*c + 1);

    gtu_channel #(.PRESCALE_W(PRESCALE_W)) u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick),
      .cfg_i  (chan_cfg_t'(cfg_q[4*c +: 4])),
      .run_i  (run_q[c]),
      .int_i  (int_s[c]),
      .pin_i  (cnt_s[c]),
      .wr_lo_i(we_i && (addr_i == A_LO)),
      .wr_hi_i(we_i && (addr_i == A_HI)),
      .wdata_i(wdata_i),
      .lo_o   (lo_w[c]),
      .hi_o   (hi_w[c]),
      .ovf_o  (ovf[c])
    );

    // R9
    tf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovf[c] && !we_ctrl) |=> tf_q[c]);
    // R9
    tf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tf_q[c] && !we_ctrl) |=> tf_q[c]);
  end

  always_comb begin
    unique case (addr_i)
      3'd0:    rdata_o = cfg_q;
      3'd1:    rdata_o = DATA_W'({tf_q, run_q});
      3'd2:    rdata_o = lo_w[0];
      3'd3:    rdata_o = hi_w[0];
      3'd4:    rdata_o = lo_w[1];
      3'd5:    rdata_o = hi_w[1];
      default: rdata_o = '0;
    endcase
  end

  assign tf_o = tf_q;

  // R4
  ovf_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ovf) |-> tick);
endmodule

// File: tb/gated_timer_unit_bench.sv
module gated_timer_unit_bench;
  localparam int MC = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] cnt_pin = '0;
  logic [1:0] int_pin = '0;
  logic [1:0] tf;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  string cur_req = "R12";

  always #5 clk = ~clk;

  gated_timer_unit u_gated_timer_unit (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .we_i     (we),
    .addr_i   (addr),
    .wdata_i  (wdata),
    .rdata_o  (rdata),
    .cnt_pin_i(cnt_pin),
    .int_pin_i(int_pin),
    .tf_o     (tf)
  );

  // behavioural reference
  int m_phase, m_mode;
  int m_lo[2], m_hi[2];
  bit m_run[2], m_tf[2], m_i1[2], m_i2[2], m_c1[2], m_c2[2], m_smp[2], m_prv[2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0;
      m_mode  = 0;
      for (int c = 0; c < 2; c++) begin
        m_lo[c] = 0; m_hi[c] = 0; m_run[c] = 0; m_tf[c] = 0;
        m_i1[c] = 0; m_i2[c] = 0; m_c1[c] = 0; m_c2[c] = 0;
        m_smp[c] = 0; m_prv[c] = 0;
      end
    end else begin
      bit tick;
      tick = (m_phase == MC - 1);
      for (int c = 0; c < 2; c++) begin
        int cfg, md, v;
        bit en, pend, inc, ovf, wl, wh;
        cfg  = (m_mode >> (4*c)) & 15;
        md   = cfg & 3;
        en   = m_run[c] && (((cfg & 8) == 0) || m_i2[c]);
        pend = m_prv[c] && !m_smp[c];
        wl   = we && (int'(addr) == 2 + 2*c);
        wh   = we && (int'(addr) == 3 + 2*c);
        inc  = tick && en && (((cfg & 4) == 0) || pend) && !wl && !wh;
        ovf  = 0;
        if (inc) begin
          case (md)
            0: if ((m_lo[c] & 31) == 31) begin
                 m_lo[c] = m_lo[c] - 31;
                 ovf = (m_hi[c] == 255);
                 m_hi[c] = (m_hi[c] + 1) % 256;
               end else m_lo[c] = m_lo[c] + 1;
            1: begin
                 v = m_hi[c]*256 + m_lo[c] + 1;
                 ovf = (v == 65536);
                 v = v % 65536;
                 m_hi[c] = v / 256;
                 m_lo[c] = v % 256;
               end
            2: if (m_lo[c] == 255) begin
                 m_lo[c] = m_hi[c];
                 ovf = 1;
               end else m_lo[c] = m_lo[c] + 1;
            default: ;
          endcase
        end
        if (wl) m_lo[c] = int'(wdata);
        if (wh) m_hi[c] = int'(wdata);
        if (ovf) m_tf[c] = 1;
        if (tick) begin
          m_prv[c] = m_smp[c];
          m_smp[c] = m_c2[c];
        end
        m_i2[c] = m_i1[c]; m_i1[c] = int_pin[c];
        m_c2[c] = m_c1[c]; m_c1[c] = cnt_pin[c];
      end
      if (we && addr == 3'd1) begin
        m_run[0] = wdata[0]; m_run[1] = wdata[1];
        m_tf[0]  = wdata[2]; m_tf[1]  = wdata[3];
      end
      if (we && addr == 3'd0) m_mode = int'(wdata);
      m_phase = (m_phase + 1) % MC;
    end
  end

  function automatic int model_reg(int a);
    case (a)
      0: return m_mode;
      1: return int'(m_run[0]) | (int'(m_run[1]) << 1) | (int'(m_tf[0]) << 2) | (int'(m_tf[1]) << 3);
      2: return m_lo[0];
      3: return m_hi[0];
      4: return m_lo[1];
      5: return m_hi[1];
      default: return 0;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cur_req, int'(rdata), model_reg(int'(addr)));
      check(cur_req, int'(tf), int'(m_tf[0]) | (int'(m_tf[1]) << 1));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(posedge clk); #1;
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic sel(logic [2:0] a);
    @(posedge clk); #1;
    addr = a;
  endtask

  task automatic rd_check(string req, logic [2:0] a, int exp);
    @(posedge clk); #1;
    addr = a;
    @(negedge clk);
    check(req, int'(rdata), exp);
  endtask

  task automatic toggle_int(int ch, int n, int seed);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      int_pin[ch] = ~int_pin[ch];
      repeat ((k * seed) % 41 + 1) @(posedge clk);
    end
  endtask

  task automatic pulse_train(int ch, int half, int n);
    repeat (n) begin
      @(posedge clk); #1;
      cnt_pin[ch] = ~cnt_pin[ch];
      repeat (half - 1) @(posedge clk);
    end
  endtask

  initial begin
    step(3);
    #1 rst_n = 1'b1;

    // R12 reset state
    cur_req = "R12";
    for (int a = 0; a < 6; a++) rd_check("R12", 3'(a), 0);
    @(negedge clk) check("R12", int'(tf), 0);

    // R1 register map readback
    cur_req = "R1";
    wr(3'd0, 8'hA5); rd_check("R1", 3'd0, 8'hA5);
    wr(3'd2, 8'h12); rd_check("R1", 3'd2, 8'h12);
    wr(3'd5, 8'h34); rd_check("R1", 3'd5, 8'h34);
    wr(3'd0, 8'h00);
    wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd5, 8'h00);

    // R4 timer mode, 16-bit
    cur_req = "R4";
    wr(3'd0, 8'h01);
    wr(3'd1, 8'h01);
    sel(3'd2);
    step(300);

    // R2 gate clear: interrupt pin ignored, run bit controls
    cur_req = "R2";
    toggle_int(0, 12, 7);
    wr(3'd1, 8'h00);
    sel(3'd2);
    toggle_int(0, 6, 5);
    wr(3'd1, 8'h01);
    sel(3'd2);
    step(100);

    // R3 gate set: run AND synchronized interrupt level
    cur_req = "R3";
    int_pin[0] = 1'b0;
    wr(3'd0, 8'h09);
    sel(3'd2);
    toggle_int(0, 30, 3);
    wr(3'd1, 8'h00);
    sel(3'd2);
    int_pin[0] = 1'b1;
    step(60);
    wr(3'd1, 8'h01);
    sel(3'd2);
    step(60);

    // R5 counter mode on channel 1
    cur_req = "R5";
    wr(3'd0, 8'h50);
    wr(3'd1, 8'h02);
    sel(3'd4);
    pulse_train(1, 12, 20);
    pulse_train(1, 30, 10);
    pulse_train(1, 5, 30);
    pulse_train(1, 19, 12);

    // R6 13-bit mode overflow
    cur_req = "R6";
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h00);
    wr(3'd2, 8'hFC);
    wr(3'd3, 8'hFF);
    wr(3'd1, 8'h01);
    sel(3'd2);
    step(MC * 6);
    @(negedge clk) check("R6", int'(tf[0]), 1);
    sel(3'd3);
    step(MC * 2);

    // R9 flag held, then cleared by writing 0
    cur_req = "R9";
    step(MC * 4);
    @(negedge clk) check("R9", int'(tf[0]), 1);
    wr(3'd1, 8'h01);
    @(negedge clk) check("R9", int'(tf[0]), 0);
    sel(3'd1);
    step(40);

    // R7 16-bit overflow
    cur_req = "R7";
    wr(3'd0, 8'h01);
    wr(3'd2, 8'hF0);
    wr(3'd3, 8'hFF);
    sel(3'd2);
    step(MC * 20);
    @(negedge clk) check("R7", int'(tf[0]), 1);
    sel(3'd3);
    step(MC * 2);
    wr(3'd1, 8'h01);

    // R8 8-bit auto reload
    cur_req = "R8";
    wr(3'd0, 8'h02);
    wr(3'd3, 8'hF0);
    wr(3'd2, 8'hFB);
    sel(3'd2);
    step(MC * 45);
    sel(3'd3);
    step(MC * 3);
    rd_check("R8", 3'd3, 8'hF0);

    // R10 write on the increment cycle wins
    cur_req = "R10";
    wr(3'd0, 8'h01);
    sel(3'd2);
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); #1;
      if (m_phase == MC - 1) break;
    end
    we = 1'b1; addr = 3'd2; wdata = 8'h55;
    @(posedge clk); #1;
    we = 1'b0;
    rd_check("R10", 3'd2, 8'h55);
    step(MC * 3);

    // R11 mode 11 holds
    cur_req = "R11";
    wr(3'd0, 8'h33);
    wr(3'd1, 8'h03);
    wr(3'd2, 8'h77);
    sel(3'd2);
    pulse_train(1, 12, 10);
    rd_check("R11", 3'd2, 8'h77);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule